// File: doc/BRIEF.md
# Enable-Aligned Millisecond Timebase with Gate Timer

This block turns a stream of 1 MHz tick pulses into a 1 kHz tick and, for frequency measurements, decides when the measurement gate closes. In the realigning modes, the millisecond divider is held at zero while the measurement is disabled. Its phase therefore restarts on the rising edge of the effective enable, and the n-th millisecond tick lands exactly n ms after the measurement opens. Without this, the start would carry up to one millisecond of error. In the other modes the divider runs freely, and the ±1 µs start error of the raw microsecond source is accepted.

In frequency mode a gate timer counts millisecond ticks up to a selected limit. When the limit is reached, the timer emits a one-cycle gate-end pulse and forces the enable output low. That is the only way a frequency gate closes. The enable output then stays low until a restart request re-arms the block. The controller drives the raw enable, the mode, the gate selection and the restart request. Downstream logic uses the enable output and the millisecond tick.

Top module: `msec_timebase`

## Requirements
- R1: After reset `ms_tick` and `gate_done` are 0 and the gate latch is armed, so `en_out` equals `meas_en`.
- R2: The divider advances only in cycles where `us_tick` is 1. `ms_tick` is a one-cycle pulse in the cycle after every DIV_RATIO-th counted `us_tick`.
- R3: In modes 0 (frequency, `mode`=00) and 3 (seconds timing, `mode`=11), the divider is held at zero while `en_out` is 0. The first `ms_tick` after `en_out` rises follows the DIV_RATIO-th `us_tick` counted from the rising cycle onward.
- R4: In modes 1 (event count, 01) and 2 (millisecond timing, 10), the divider runs freely. It produces `ms_tick` every DIV_RATIO `us_tick`s whatever the value of `en_out`.
- R5: In mode 0, `gate_sel` picks the gate length in millisecond ticks: 00 gives GATE_SHORT, 01 gives GATE_MID, 10 gives GATE_LONG, and the reserved 11 gives GATE_MID. `gate_done` is 1 in the cycle after the tick that completes the gate.
- R6: The gate timer only acts in mode 0. In any other mode, `gate_done` never fires and `en_out` follows `meas_en`.
- R7: `en_out` is `meas_en` AND the gate latch. A gate end clears the latch, in the same cycle that `gate_done` rises. The latch stays clear, whatever `meas_en` does, until a restart request sets it again.
- R8: A restart request in the same cycle as the completing tick wins. No `gate_done` is produced, `en_out` stays high, and the gate count starts again from zero.
- R9: `gate_done` never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle 1 MHz tick pulse |
| meas_en | input | 1 | Raw measurement enable from the controller |
| restart | input | 1 | Re-arm request for the gate latch |
| mode | input | 2 | 00 frequency, 01 event count, 10 ms timing, 11 s timing |
| gate_sel | input | 2 | Gate length selection, frequency mode |
| ms_tick | output | 1 | One-cycle 1 kHz tick pulse |
| gate_done | output | 1 | One-cycle gate-end pulse |
| en_out | output | 1 | Effective measurement enable |

## Verification
The completing millisecond tick of a frequency gate and a restart request can land in the same cycle. In that case the gate end and the re-arm compete for the latch and for the gate counter. The bench provokes the collision by driving the restart request in exactly the cycle in which the final tick is visible. It then judges three things: that no gate-end pulse appears, that the enable output stays high, and that the next gate end comes a full gate length later.

// File: rtl/msec_timebase_pkg.sv
// Shared definitions for the millisecond timebase.
// Assumes: mode encoding is fixed by the controller interface.
package msec_timebase_pkg;
    typedef enum logic [1:0] {
        MODE_FREQ   = 2'd0,
        MODE_EVENTS = 2'd1,
        MODE_MSEC   = 2'd2,
        MODE_SEC    = 2'd3
    } meas_mode_e;

    // True for the modes whose divider phase follows the enable edge.
    function automatic logic phase_follows_enable(meas_mode_e m);
        return (m == MODE_FREQ) || (m == MODE_SEC);
    endfunction
endpackage

// File: rtl/msec_phase_div.sv
// Modulo-DIV counter of microsecond ticks producing a one-cycle tick on wrap.
// Assumes: us_tick is a single-cycle pulse; hold_zero overrides counting.
module msec_phase_div #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic hold_zero,
    output logic ms_tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count microsecond ticks, wrap at DIV and flag the wrap for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ms_tick <= 1'b0;
        end else begin
            ms_tick <= 1'b0;
            if (hold_zero) begin
                cnt_q <= '0;
            end else if (us_tick) begin
                if (cnt_q == LAST) begin
                    cnt_q   <= '0;
                    ms_tick <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/msec_gate_ctl.sv
// Gate timer: counts millisecond ticks in frequency mode and closes the gate
// after the selected length; holds the gate latch clear until restart.
// Assumes: ms_tick is a single-cycle pulse; restart has priority.
module msec_gate_ctl #(
    parameter int G_SHORT = 100,
    parameter int G_MID   = 1000,
    parameter int G_LONG  = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       meas_en,
    input  logic       restart,
    input  logic       freq_mode,
    input  logic [1:0] gate_sel,
    output logic       gate_done,
    output logic       en_out
);
    localparam int GMAX = (G_LONG > G_MID) ? ((G_LONG > G_SHORT) ? G_LONG : G_SHORT)
                                           : ((G_MID > G_SHORT) ? G_MID : G_SHORT);
    localparam int GW = $clog2(GMAX + 1);
    localparam int NSEL = 4;
    // Selection code to gate length; the reserved code reuses the middle length.
    localparam int LIMITS [NSEL] = '{G_SHORT, G_MID, G_LONG, G_MID};

    logic          armed_q;
    logic [GW-1:0] gcnt_q;
    logic [GW-1:0] last_idx;

    // Index of the tick that completes the currently selected gate.
    always_comb begin
        last_idx = '0;
        for (int s = 0; s < NSEL; s++) begin
            if (gate_sel == 2'(s)) last_idx = GW'(LIMITS[s] - 1);
        end
    end

    // Effective enable: raw request qualified by the gate latch.
    assign en_out = meas_en & armed_q;

    // Gate counting, latch handling and the single-cycle gate-end flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b1;
            gcnt_q    <= '0;
            gate_done <= 1'b0;
        end else begin
            gate_done <= 1'b0;
            if (restart) begin
                armed_q <= 1'b1;
                gcnt_q  <= '0;
            end else if (!freq_mode || !en_out) begin
                gcnt_q <= '0;
            end else if (ms_tick) begin
                if (gcnt_q == last_idx) begin
                    gcnt_q    <= '0;
                    armed_q   <= 1'b0;
                    gate_done <= 1'b1;
                end else begin
                    gcnt_q <= gcnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/msec_timebase.sv
// Top of the enable-aligned millisecond timebase with frequency gate timer.
// Assumes: us_tick is a one-cycle pulse at 1 MHz in the clk domain.
module msec_timebase #(
    parameter int DIV_RATIO  = 1000,
    parameter int GATE_SHORT = 100,
    parameter int GATE_MID   = 1000,
    parameter int GATE_LONG  = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       meas_en,
    input  logic       restart,
    input  logic [1:0] mode,
    input  logic [1:0] gate_sel,
    output logic       ms_tick,
    output logic       gate_done,
    output logic       en_out
);
    import msec_timebase_pkg::*;

    meas_mode_e mode_e;
    logic       hold_zero;
    logic       freq_mode;

    // Decode the mode and the divider hold condition.
    always_comb begin
        mode_e    = meas_mode_e'(mode);
        freq_mode = (mode_e == MODE_FREQ);
        hold_zero = phase_follows_enable(mode_e) & ~en_out;
    end

    msec_phase_div #(
        .DIV (DIV_RATIO)
    ) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .hold_zero (hold_zero),
        .ms_tick   (ms_tick)
    );

    msec_gate_ctl #(
        .G_SHORT (GATE_SHORT),
        .G_MID   (GATE_MID),
        .G_LONG  (GATE_LONG)
    ) i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .meas_en   (meas_en),
        .restart   (restart),
        .freq_mode (freq_mode),
        .gate_sel  (gate_sel),
        .gate_done (gate_done),
        .en_out    (en_out)
    );
endmodule

// File: rtl/msec_timebase_chk.sv
// Temporal checks on the timebase ports, bound to every instance of the top.
// Assumes: DIV_RATIO of at least 2.
module msec_timebase_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       us_tick,
    input logic       meas_en,
    input logic       restart,
    input logic [1:0] mode,
    input logic [1:0] gate_sel,
    input logic       ms_tick,
    input logic       gate_done,
    input logic       en_out
);
    logic realign;
    assign realign = (mode == 2'd0) || (mode == 2'd3);

    a_r2_tick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ms_tick |=> !ms_tick);

    a_r3_held_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (realign && !en_out) ##1 (realign && !en_out) |=> !ms_tick);

    a_r6_gate_freq_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_done) |-> $past(mode) == 2'd0);

    a_r7_closed_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        gate_done |-> !en_out);

    a_r7_stays_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_done && !restart) |=> !en_out);

    a_r8_restart_wins: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !gate_done);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        gate_done |=> !gate_done);
endmodule

bind msec_timebase msec_timebase_chk i_chk (.*);

// File: tb/test_msec_timebase.sv
`timescale 1ns/1ps
module test_msec_timebase;
    localparam int DIV = 10;
    localparam int GS  = 4;
    localparam int GM  = 6;
    localparam int GL  = 9;
    localparam int WIN = 120;
    localparam int NV  = 5;
    // Vector table: mode, gate selection, expected gate-end cycle (0 = none).
    localparam logic [1:0] V_MODE [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd3};
    localparam logic [1:0] V_SEL  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1};
    localparam int         V_END  [NV] = '{DIV*GS+1, DIV*GM+1, DIV*GL+1, DIV*GM+1, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b1;
    logic meas_en = 1'b0;
    logic restart = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [1:0] gate_sel = 2'd0;
    logic ms_tick, gate_done, en_out;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    msec_timebase #(
        .DIV_RATIO (DIV), .GATE_SHORT (GS), .GATE_MID (GM), .GATE_LONG (GL)
    ) i_msec_timebase (
        .clk (clk), .rst_n (rst_n), .us_tick (us_tick), .meas_en (meas_en),
        .restart (restart), .mode (mode), .gate_sel (gate_sel),
        .ms_tick (ms_tick), .gate_done (gate_done), .en_out (en_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rearm(input logic [1:0] m, input logic [1:0] s);
        @(negedge clk);
        meas_en = 1'b0; mode = m; gate_sel = s; restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        repeat (DIV + 2) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int first, dk, lowk, ndone, nt, t1, t2;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ms_tick after reset", ms_tick, 0);
        chk("R1 gate_done after reset", gate_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        mode = 2'd1; meas_en = 1'b1;
        #0.5;
        chk("R1 armed after reset (R7 en_out)", en_out, 1);
        meas_en = 1'b0;

        // Table walk: R3 first tick, R5 gate length, R6, R7, R9
        for (int i = 0; i < NV; i++) begin
            rearm(V_MODE[i], V_SEL[i]);
            meas_en = 1'b1;
            first = 0; dk = 0; lowk = 0; ndone = 0;
            for (int k = 1; k <= WIN; k++) begin
                @(negedge clk);
                if (ms_tick && first == 0) first = k;
                if (gate_done) begin ndone++; if (dk == 0) dk = k; end
                if (!en_out && lowk == 0) lowk = k;
            end
            chk($sformatf("R3 first tick vec %0d", i), first, DIV);
            chk($sformatf("R5 gate end cycle vec %0d", i), dk, V_END[i]);
            chk($sformatf("R9 single gate_done vec %0d", i), ndone, (V_END[i] != 0) ? 1 : 0);
            chk($sformatf("R7 en_out drop cycle vec %0d (R6 none)", i), lowk, V_END[i]);
            meas_en = 1'b0;
        end

        // R4: free-running divider in ms timing mode with enable low
        rearm(2'd2, 2'd0);
        t1 = 0; t2 = 0;
        for (int k = 1; k <= 3 * DIV; k++) begin
            @(negedge clk);
            if (ms_tick) begin if (t1 == 0) t1 = k; else if (t2 == 0) t2 = k; end
        end
        chk("R4 free-run period", t2 - t1, DIV);

        // R3: seconds mode divider held with enable low
        rearm(2'd3, 2'd0);
        nt = 0;
        for (int k = 1; k <= 3 * DIV; k++) begin
            @(negedge clk);
            if (ms_tick) nt++;
        end
        chk("R3 no tick while held", nt, 0);

        // R2: no advance without us_tick, then tick after DIV counted ticks
        rearm(2'd0, 2'd2);
        us_tick = 1'b0; meas_en = 1'b1;
        nt = 0;
        for (int k = 1; k <= 3 * DIV; k++) begin
            @(negedge clk);
            if (ms_tick) nt++;
        end
        chk("R2 no tick without us_tick", nt, 0);
        us_tick = 1'b1;
        first = 0;
        for (int k = 1; k <= 2 * DIV; k++) begin
            @(negedge clk);
            if (ms_tick && first == 0) first = k;
        end
        chk("R2 tick after DIV us_ticks", first, DIV);
        meas_en = 1'b0;

        // R7: latch stays clear across meas_en toggle until restart
        rearm(2'd0, 2'd0);
        meas_en = 1'b1;
        repeat (DIV * GS + 3) @(negedge clk);
        meas_en = 1'b0;
        repeat (2) @(negedge clk);
        meas_en = 1'b1;
        lowk = 1; nt = 0;
        for (int k = 1; k <= 2 * DIV; k++) begin
            @(negedge clk);
            if (en_out) lowk = 0;
            if (ms_tick) nt++;
        end
        chk("R7 en_out held low after gate end", lowk, 1);
        chk("R7 no tick while closed", nt, 0);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk("R7 restart re-opens", en_out, 1);
        meas_en = 1'b0;

        // R8: restart coincides with completing tick
        rearm(2'd0, 2'd0);
        meas_en = 1'b1;
        dk = 0;
        for (int k = 1; k <= 2 * DIV * GS + 5; k++) begin
            @(negedge clk);
            if (k == DIV * GS) begin
                chk("R2 completing tick present", ms_tick, 1);
                restart = 1'b1;
            end else if (k == DIV * GS + 1) begin
                restart = 1'b0;
                chk("R8 no gate_done on collision", gate_done, 0);
                chk("R8 en_out kept high", en_out, 1);
            end else begin
                if (gate_done && dk == 0) dk = k;
                if (k == 2 * DIV * GS + 2) chk("R9 gate_done cleared", gate_done, 0);
            end
        end
        chk("R8 next gate end a full gate later", dk, 2 * DIV * GS + 1);
        meas_en = 1'b0;

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule